// File: doc/BRIEF.md
# Doubleword ECC Line Checker

This block checks a cache line made of four 64-bit data doublewords. Each doubleword is stored with an 8-bit check byte. It takes the line as a stream of beats over a valid/ready handshake. Each beat carries a doubleword, the check byte stored with it, and the beat's offset within the line. For every beat the block computes the check byte again from the data and compares it with the stored one. It classifies a mismatch as either a single-bit error or a multi-bit error.

Check bit `i` is the even parity of the doubleword ANDed with a fixed 64-bit selection pattern. Pattern 0 is `0x0738C808099264FF`. Each later pattern is the one before it rotated left by eight bits. The XOR of the computed byte and the stored byte is the syndrome.

While a line is in progress the block keeps a running summary: a bad-doubleword mask and sticky single-error and multi-error flags. When the last beat has been taken, it pulses a done strobe and holds the finished summary until the next line begins. Beats that arrive out of order abandon the line and raise a sequence-error strobe. The block only reports errors. It does not correct data and does not access the cache arrays.

Top module: `ecc_line_checker`

## Requirements
- R1: Check bit i (i = 0..7) is the XOR reduction of the data ANDed with pattern i. Pattern 0 is 0x0738C808099264FF, and pattern i is pattern 0 rotated left by 8·i bits. A beat whose stored byte equals this value is not bad.
- R2: A beat is bad when its syndrome (computed byte XOR stored byte) is non-zero. A bad beat at offset k sets `bad_mask` bit (3 − k), so offset 0 maps to bit 3.
- R3: A syndrome with exactly one bit set raises `single_err`.
- R4: A non-zero syndrome with two or more bits set raises `multi_err`.
- R5: `bad_mask`, `single_err` and `multi_err` accumulate by OR across the beats of a line. They are updated in the cycle after each accepted beat.
- R6: `line_done` is high for exactly one cycle, in the cycle after the offset-3 beat is accepted. In that cycle the outputs show the final summary of the line. The summary is held after that.
- R7: `in_ready` is high at all times except while `line_done` is high. A beat offered while ready is low has no effect.
- R8: Accepting an in-order offset-0 beat clears the previous summary and starts a new one from that beat alone.
- R9: Offsets must be accepted in the order 0, 1, 2, 3. If an accepted beat's offset differs from the expected one, `seq_err` pulses for one cycle and the beat is discarded. The summary is cleared, no `line_done` follows, and the next expected offset is 0.
- R10: After reset, `line_done`, `seq_err`, `bad_mask`, `single_err` and `multi_err` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be taken this cycle |
| in_offset | input | 2 | Position of the beat within the line |
| in_data | input | 64 | Data doubleword |
| in_check | input | 8 | Stored check byte |
| line_done | output | 1 | One-cycle strobe: line finished |
| bad_mask | output | 4 | Bad doublewords, bit 3 = offset 0 |
| single_err | output | 1 | Sticky single-bit error in the line |
| multi_err | output | 1 | Sticky multi-bit error in the line |
| seq_err | output | 1 | One-cycle strobe: out-of-order beat, line discarded |

## Verification
Every result is due exactly one clock edge after the beat that causes it is accepted. This holds for the running mask and flags, the `line_done` strobe after offset 3, and the `seq_err` strobe. The bench therefore drives each beat on a falling edge and lets one rising edge accept it. It compares at the next falling edge against a summary it computes from its own rotated patterns and syndrome popcount. The cycle after that falling edge is checked separately, to confirm that `line_done` and `seq_err` have dropped and that the summary is held.

// File: rtl/ecc_line_pkg.sv
// Shared constants and helpers for the doubleword ECC line checker.
// Assumes 64-bit data and 8 check bits; the pattern rotation step is 64/8.
package ecc_line_pkg;
    localparam int DW      = 64;
    localparam int CW      = 8;
    localparam int ROT     = DW / CW;
    localparam logic [DW-1:0] BASE_PATTERN = 64'h0738_C808_0992_64FF;

    // Selection pattern for check bit idx: base rotated left by ROT*idx.
    function automatic logic [DW-1:0] sel_pattern(input int idx);
        logic [2*DW-1:0] dbl;
        dbl = {BASE_PATTERN, BASE_PATTERN};
        return dbl[2*DW-1-ROT*idx -: DW];
    endfunction

    // Per-beat verdict.
    typedef struct packed {
        logic bad;
        logic single;
        logic multi;
    } beat_verdict_t;
endpackage

// File: rtl/ecc_check_gen.sv
// Computes the check byte of one doubleword.
// Each output bit is the even parity of the data under its selection pattern.
// Purely combinational.
module ecc_check_gen
    import ecc_line_pkg::*;
(
    input  logic [DW-1:0] data,
    output logic [CW-1:0] check
);
    for (genvar g = 0; g < CW; g++) begin : g_bit
        localparam logic [DW-1:0] PAT = sel_pattern(g);
        // Parity of the selected data bits.
        assign check[g] = ^(data & PAT);
    end
endmodule

// File: rtl/ecc_classify.sv
// Forms the syndrome from the computed and stored check bytes and classifies it.
// A one-hot syndrome is a single-bit error; any other non-zero syndrome is multi-bit.
module ecc_classify
    import ecc_line_pkg::*;
(
    input  logic [CW-1:0]  computed,
    input  logic [CW-1:0]  stored,
    output beat_verdict_t  verdict
);
    logic [CW-1:0] syndrome;

    // Syndrome and its classification.
    always_comb begin
        syndrome       = computed ^ stored;
        verdict.bad    = |syndrome;
        verdict.single = $onehot(syndrome);
        verdict.multi  = verdict.bad && !verdict.single;
    end
endmodule

// File: rtl/ecc_line_track.sv
// Tracks the beat order within a line and accumulates the line summary.
// Assumes beats come in offset order 0..BEATS-1. A mismatched offset discards the line.
// Results are registered, so they appear one cycle after acceptance.
module ecc_line_track
    import ecc_line_pkg::*;
#(
    parameter int BEATS = 4,
    localparam int OW   = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [OW-1:0] offset,
    input  beat_verdict_t verdict,
    output logic          done,
    output logic          seq_err,
    output logic [BEATS-1:0] mask,
    output logic          single_err,
    output logic          multi_err
);
    localparam logic [OW-1:0] LAST = OW'(BEATS - 1);

    logic [OW-1:0]    exp_off;
    logic [BEATS-1:0] beat_bit;

    // Mask contribution of the current beat: bit (BEATS-1-offset).
    always_comb begin
        beat_bit = '0;
        for (int b = 0; b < BEATS; b++) begin
            if (offset == OW'(BEATS - 1 - b)) beat_bit[b] = verdict.bad;
        end
    end

    // Sequence tracking, summary accumulation and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_off    <= '0;
            mask       <= '0;
            single_err <= 1'b0;
            multi_err  <= 1'b0;
            done       <= 1'b0;
            seq_err    <= 1'b0;
        end else begin
            done    <= 1'b0;
            seq_err <= 1'b0;
            if (accept) begin
                if (offset != exp_off) begin
                    seq_err    <= 1'b1;
                    exp_off    <= '0;
                    mask       <= '0;
                    single_err <= 1'b0;
                    multi_err  <= 1'b0;
                end else begin
                    if (offset == '0) begin
                        mask       <= beat_bit;
                        single_err <= verdict.single;
                        multi_err  <= verdict.multi;
                    end else begin
                        mask       <= mask | beat_bit;
                        single_err <= single_err | verdict.single;
                        multi_err  <= multi_err | verdict.multi;
                    end
                    exp_off <= (offset == LAST) ? '0 : exp_off + 1'b1;
                    done    <= (offset == LAST);
                end
            end
        end
    end
endmodule

// File: rtl/ecc_line_checker.sv
// Top level: checks a line of four ECC-protected doublewords arriving as a stream.
// Ready drops only in the single cycle of the done strobe.
module ecc_line_checker
    import ecc_line_pkg::*;
#(
    parameter int BEATS = 4,
    localparam int OW   = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OW-1:0]    in_offset,
    input  logic [DW-1:0]    in_data,
    input  logic [CW-1:0]    in_check,
    output logic             line_done,
    output logic [BEATS-1:0] bad_mask,
    output logic             single_err,
    output logic             multi_err,
    output logic             seq_err
);
    logic [CW-1:0] computed;
    beat_verdict_t verdict;
    logic          accept;

    // Handshake: blocked only while the done strobe is high.
    assign in_ready = !line_done;
    assign accept   = in_valid && in_ready;

    ecc_check_gen u_gen (
        .data  (in_data),
        .check (computed)
    );

    ecc_classify u_cls (
        .computed (computed),
        .stored   (in_check),
        .verdict  (verdict)
    );

    ecc_line_track #(.BEATS(BEATS)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .offset     (in_offset),
        .verdict    (verdict),
        .done       (line_done),
        .seq_err    (seq_err),
        .mask       (bad_mask),
        .single_err (single_err),
        .multi_err  (multi_err)
    );
endmodule

// File: rtl/ecc_line_checker_sva.sv
// Protocol and summary properties of ecc_line_checker, attached by bind.
module ecc_line_checker_sva #(
    parameter int BEATS = 4,
    localparam int OW   = $clog2(BEATS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [OW-1:0]    in_offset,
    input logic             line_done,
    input logic [BEATS-1:0] bad_mask,
    input logic             single_err,
    input logic             multi_err,
    input logic             seq_err
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> $past(in_valid && in_ready && in_offset == OW'(BEATS - 1))); // R6
    AST_READY_LOW_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == !line_done); // R7
    AST_FLAGS_NEED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (single_err || multi_err) |-> bad_mask != '0); // R2
    AST_SEQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (bad_mask == '0 && !single_err && !multi_err && !line_done)); // R9
    AST_SEQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> $past(in_valid && in_ready)); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid && in_ready) && !seq_err) |-> $stable(bad_mask)); // R5
endmodule

bind ecc_line_checker ecc_line_checker_sva #(.BEATS(BEATS)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_offset  (in_offset),
    .line_done  (line_done),
    .bad_mask   (bad_mask),
    .single_err (single_err),
    .multi_err  (multi_err),
    .seq_err    (seq_err)
);

// File: tb/ecc_line_checker_bench.sv
`timescale 1ns/1ps
// Self-checking sweep over error kinds at every offset of a line.
module ecc_line_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_offset = '0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_check = '0;
    logic        line_done;
    logic [3:0]  bad_mask;
    logic        single_err;
    logic        multi_err;
    logic        seq_err;

    int checks = 0;
    int fails  = 0;
    logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;
    logic [3:0]  em;
    logic        es, emu;

    always #5 clk = ~clk;

    ecc_line_checker u_ecc_line_checker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_offset(in_offset), .in_data(in_data), .in_check(in_check),
        .line_done(line_done), .bad_mask(bad_mask), .single_err(single_err),
        .multi_err(multi_err), .seq_err(seq_err)
    );

    // Bench model of the check byte, with the patterns rotated here.
    function automatic logic [7:0] ref_check(input logic [63:0] d);
        logic [63:0] p;
        logic [7:0]  c;
        p = 64'h0738C808099264FF;
        for (int i = 0; i < 8; i++) begin
            c[i] = ^(d & p);
            p = {p[55:0], p[63:56]};
        end
        return c;
    endfunction

    function automatic int pop8(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x ^= x << 13; x ^= x >> 7; x ^= x << 17;
        return x;
    endfunction

    // Offer one beat, let a rising edge take it, return at the next falling edge.
    task automatic beat(input logic [1:0] off, input logic [63:0] d, input logic [7:0] c);
        in_valid = 1'b1; in_offset = off; in_data = d; in_check = c;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Update the bench summary for an in-order beat.
    task automatic model(input logic [1:0] off, input logic [63:0] d, input logic [7:0] c);
        logic [7:0] syn;
        syn = ref_check(d) ^ c;
        if (off == 2'd0) begin em = '0; es = 1'b0; emu = 1'b0; end
        if (syn != 0) em[3-off] = 1'b1;
        if (pop8(syn) == 1) es = 1'b1;
        if (pop8(syn) > 1) emu = 1'b1;
    endtask

    task automatic check_summary(input string req);
        check({req, " mask"}, 32'(bad_mask), 32'(em));
        check({req, " single"}, 32'(single_err), 32'(es));
        check({req, " multi"}, 32'(multi_err), 32'(emu));
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [7:0]  c;
        em = '0; es = 1'b0; emu = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 done", 32'(line_done), 0);
        check("R10 ready", 32'(in_ready), 1);
        check("R10 seq", 32'(seq_err), 0);
        check_summary("R10");

        // R1: all-ones and all-zero data with correct check bytes are clean
        beat(2'd0, '1, ref_check('1)); model(2'd0, '1, ref_check('1));
        check_summary("R1 ones");
        beat(2'd1, '0, 8'h00); model(2'd1, '0, 8'h00);
        check_summary("R1 zero");
        beat(2'd2, 64'h1, ref_check(64'h1)); model(2'd2, 64'h1, ref_check(64'h1));
        beat(2'd3, 64'h8000_0000_0000_0000, ref_check(64'h8000_0000_0000_0000));
        model(2'd3, 64'h8000_0000_0000_0000, ref_check(64'h8000_0000_0000_0000));
        check("R6 done", 32'(line_done), 1);
        check_summary("R1 final");
        @(negedge clk);

        // Sweep all 4^4 combinations of error kind per offset (R2 R3 R4 R5 R6 R8)
        for (int line = 0; line < 256; line++) begin
            for (int off = 0; off < 4; off++) begin
                int kind;
                kind = (line >> (2 * off)) & 3;
                lfsr = next_rand(lfsr);
                d = lfsr;
                c = ref_check(d);
                case (kind)
                    1: c = c ^ (8'h01 << ((line + off) % 8));
                    2: d = d ^ (64'h1 << ((line * 7 + off * 13) % 64));
                    3: c = c ^ 8'h81;
                    default: ;
                endcase
                beat(2'(off), d, c);
                model(2'(off), d, c);
                check_summary(off == 0 ? "R8 R2" : "R5 R3 R4");
                check("R6 done timing", 32'(line_done), (off == 3) ? 1 : 0);
            end
            // Done cycle: ready low; an offered bogus beat must not be taken (R7)
            check("R7 ready", 32'(in_ready), 0);
            in_valid = 1'b1; in_offset = 2'd2; in_data = '0; in_check = 8'hFF;
            @(posedge clk); @(negedge clk);
            in_valid = 1'b0;
            check("R6 pulse", 32'(line_done), 0);
            check("R7 ignored seq", 32'(seq_err), 0);
            check_summary("R6 hold");
        end

        // R9: offsets 0,1 then 3 -> sequence error, line discarded
        beat(2'd0, '0, 8'h01); model(2'd0, '0, 8'h01);
        beat(2'd1, '0, 8'h03); model(2'd1, '0, 8'h03);
        check_summary("R9 partial");
        beat(2'd3, '0, 8'h00);
        em = '0; es = 1'b0; emu = 1'b0;
        check("R9 seq", 32'(seq_err), 1);
        check("R9 no done", 32'(line_done), 0);
        check_summary("R9 cleared");
        @(negedge clk);
        check("R9 seq pulse", 32'(seq_err), 0);
        // R9: repeated offset 0 is also out of order
        beat(2'd0, '0, 8'h00);
        beat(2'd0, '0, 8'h10);
        check("R9 repeat seq", 32'(seq_err), 1);
        check_summary("R9 repeat");
        // R9: after a discard a full line is accepted from offset 0
        for (int off = 0; off < 4; off++) begin
            beat(2'(off), 64'hDEAD_BEEF_0000_0000 + 64'(off), 8'h00);
            model(2'(off), 64'hDEAD_BEEF_0000_0000 + 64'(off), 8'h00);
        end
        check("R9 recover done", 32'(line_done), 1);
        check_summary("R9 recover");
        @(negedge clk);
        // R9: a line starting at offset 2 is rejected
        beat(2'd2, '0, 8'h00);
        check("R9 start seq", 32'(seq_err), 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule